// File: doc/BRIEF.md
# Alternate Zero-Crossing Pulse Gater

This block sits behind a mains zero-crossing detector. That detector emits one active-high pulse at each crossing, so two pulses arrive per mains cycle. The raw pulse is asynchronous, so the block first samples it with a fast system clock. It then removes noise from it, and the cleaned pulse goes out unchanged.

From the cleaned pulse the block builds a half-rate phase bit. The phase bit flips only when a cleaned pulse ends, so it holds steady through the whole of every pulse. The gate output is a registered NAND of the cleaned pulse and the phase bit. It goes low for the full width of every second pulse and stays high otherwise. It can feed phase-control logic that should act on only one polarity of the mains.

A slow or chattering trailing edge is the main hazard. The filter only accepts a level change after the new level has held for a set number of consecutive samples. Because of this, one pulse always gives exactly one phase flip. The cost is a fixed lag behind the true crossing.

Top module: `zc_gater`

## Requirements
- R1: The raw input passes through SYNC_STAGES (default 2) flops and then the filter. A level change on the raw input that holds shows on `pulse_o` exactly FILT_CYCLES+SYNC_STAGES clock edges after it is first sampled.
- R2: A level run on the raw input shorter than FILT_CYCLES samples is ignored. The state of `pulse_o`, `phase_o` and `gate_o` stays unchanged.
- R3: An accepted pulse that is N samples wide gives a `pulse_o` high for exactly N cycles, provided N >= FILT_CYCLES.
- R4: `phase_o` toggles exactly once per accepted pulse. It toggles one clock after `pulse_o` falls and never while `pulse_o` is high.
- R5: `gate_o` is low only when the previous cycle had `pulse_o` = 1 and `phase_o` = 1. It is therefore low for every second accepted pulse, for the same number of cycles as that pulse.
- R6: A trailing edge that chatters gives one phase toggle only. The chatter consists of low and high runs, each shorter than FILT_CYCLES samples.
- R7: A synchronous reset clears the filter, `pulse_o` and `phase_o`, and sets `gate_o` = 1. The first accepted pulse after reset leaves `gate_o` high, and the second drives it low.
- R8: `gate_o` is registered. It changes one clock after `pulse_o` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| zc_raw_i | input | 1 | Asynchronous zero-crossing pulse, active high |
| pulse_o | output | 1 | Filtered, synchronized pulse |
| phase_o | output | 1 | Half-rate phase bit |
| gate_o | output | 1 | Registered NAND of pulse and phase; low on alternate pulses |

## Verification
The phase flip and the release of the gate happen on the same clock edge: the edge after the cleaned pulse falls. The gate register samples the old phase together with a cleared pulse, while the phase register flips. The bench provokes this with every pulse in its table. For each pulse it counts the samples in which the gate is low and compares that count with the pulse width. A gate that took the new phase, or that lagged by a cycle, would show a count off by one, or low cycles on the wrong pulse. The count of phase flips per pulse confirms that the flip fell only after the trailing edge.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_FILT_CYCLES = 50;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/zcg_sync.sv
module zcg_sync #(
  parameter int unsigned STAGES = zcg_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];

  initial begin
    a_r1_min_stages: assert (STAGES >= 2);
  end
endmodule

// File: rtl/zcg_filter.sv
module zcg_filter #(
  parameter int unsigned FILT_CYCLES = zcg_pkg::DEF_FILT_CYCLES
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic clean_o
);
  localparam int unsigned CW = zcg_pkg::cnt_width(FILT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic          level;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      level   <= 1'b0;
    end else if (sync_i == level) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      level   <= ~level;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign clean_o = level;

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LAST);

  a_r2_flip_needs_diff: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> ($past(sync_i) != $past(level)));
endmodule

// File: rtl/zcg_phase.sv
module zcg_phase (
  input  logic clk,
  input  logic rst,
  input  logic clean_i,
  output logic phase_o
);
  logic prev;
  logic fall;
  logic phase;

  assign fall = prev & ~clean_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      phase <= 1'b0;
    end else begin
      prev  <= clean_i;
      phase <= phase ^ fall;
    end
  end

  assign phase_o = phase;

  a_r4_toggle_after_fall: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (!$past(clean_i) && $past(prev)));

  a_r4_steady_in_pulse: assert property (@(posedge clk) disable iff (rst)
    ($past(clean_i) && clean_i) |-> $stable(phase));
endmodule

// File: rtl/zc_gater.sv
module zc_gater #(
  parameter int unsigned SYNC_STAGES = zcg_pkg::DEF_SYNC_STAGES,
  parameter int unsigned FILT_CYCLES = zcg_pkg::DEF_FILT_CYCLES
) (
  input  logic clk,
  input  logic rst,
  input  logic zc_raw_i,
  output logic pulse_o,
  output logic phase_o,
  output logic gate_o
);
  logic sync_s;
  logic clean_s;
  logic phase_s;
  logic gate_q;

  zcg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(zc_raw_i), .sync_o(sync_s)
  );

  zcg_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
    .clk(clk), .rst(rst), .sync_i(sync_s), .clean_o(clean_s)
  );

  zcg_phase u_phase (
    .clk(clk), .rst(rst), .clean_i(clean_s), .phase_o(phase_s)
  );

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b1;
    else     gate_q <= ~(clean_s & phase_s);
  end

  assign pulse_o = clean_s;
  assign phase_o = phase_s;
  assign gate_o  = gate_q;

  a_r5_gate_low_cause: assert property (@(posedge clk) disable iff (rst)
    !gate_o |-> ($past(pulse_o) && $past(phase_o)));

  a_r8_gate_follows_pulse: assert property (@(posedge clk) disable iff (rst)
    ($past(pulse_o) && $past(phase_o) && pulse_o) |-> !gate_o);

  a_r7_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (gate_o && !phase_o && !pulse_o));
endmodule

// File: tb/test_zc_gater.sv
module test_zc_gater;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 8;
  localparam int SYNC = 2;
  localparam int GAP = 40;
  localparam int NV = 8;
  localparam int VW [NV] = '{40, 8, 100, 7, 3, 55, 8, 30};
  localparam bit VA [NV] = '{1, 1, 1, 0, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic zc = 1'b0;
  logic pulse, phase, gate;

  int total = 0;
  int bad = 0;
  bit exp_phase = 1'b0;
  int hi_cnt, lo_cnt, tog_cnt;
  logic last_phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_gater #(.SYNC_STAGES(SYNC), .FILT_CYCLES(FILT)) i_zc_gater (
    .clk(clk), .rst(rst), .zc_raw_i(zc),
    .pulse_o(pulse), .phase_o(phase), .gate_o(gate)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (pulse) hi_cnt++;
    if (!gate) lo_cnt++;
    if (phase != last_phase) tog_cnt++;
    last_phase = phase;
  endtask

  task automatic hold(input logic lvl, input int n);
    zc = lvl;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_counts();
    hi_cnt = 0; lo_cnt = 0; tog_cnt = 0; last_phase = phase;
  endtask

  task automatic do_reset();
    rst = 1'b1; zc = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    exp_phase = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R7: reset state
    check("R7 pulse after reset", pulse, 0);
    check("R7 phase after reset", phase, 0);
    check("R7 gate after reset", gate, 1);

    // R1: latency of exactly FILT+SYNC edges; R7 first pulse not gated
    clear_counts();
    zc = 1'b1;
    for (int i = 0; i < FILT + SYNC - 1; i++) tick();
    check("R1 pulse before latency", pulse, 0);
    tick();
    check("R1 pulse at latency", pulse, 1);
    tick();
    check("R7 first pulse gate high", gate, 1);
    hold(1'b1, 20);
    hold(1'b0, GAP);
    exp_phase = ~exp_phase;
    check("R4 phase after first pulse", phase, exp_phase);
    check("R7 first pulse gate low count", lo_cnt, 0);

    // Vector table walk: R2 R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      clear_counts();
      hold(1'b1, VW[v]);
      hold(1'b0, GAP);
      if (VA[v]) begin
        check("R3 pulse width", hi_cnt, VW[v]);
        check("R5 R8 gate low width", lo_cnt, exp_phase ? VW[v] : 0);
        check("R4 one toggle", tog_cnt, 1);
        exp_phase = ~exp_phase;
      end else begin
        check("R2 short run no pulse", hi_cnt, 0);
        check("R2 short run no toggle", tog_cnt, 0);
        check("R2 short run gate", lo_cnt, 0);
      end
      check("R5 gate idle high", gate, 1);
      check("R4 phase tracks", phase, exp_phase);
    end

    // R6: chattering trailing edge
    clear_counts();
    hold(1'b1, 40);
    hold(1'b0, 3);
    hold(1'b1, 2);
    hold(1'b0, 5);
    hold(1'b1, 4);
    hold(1'b0, GAP);
    check("R6 single toggle on noisy edge", tog_cnt, 1);
    check("R6 pulse spans chatter", hi_cnt, 54);
    check("R6 gate low span", lo_cnt, exp_phase ? 54 : 0);
    exp_phase = ~exp_phase;
    check("R6 phase tracks", phase, exp_phase);

    // R7: reset in the middle of a gated pulse
    if (!exp_phase) begin
      hold(1'b1, 20);
      hold(1'b0, GAP);
      exp_phase = ~exp_phase;
    end
    hold(1'b1, FILT + SYNC + 5);
    check("R5 gate low inside gated pulse", gate, 0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    zc = 1'b0;
    check("R7 gate high after mid reset", gate, 1);
    check("R7 phase cleared after mid reset", phase, 0);
    check("R7 pulse cleared after mid reset", pulse, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule